// File: doc/BRIEF.md
# Configurable Interrupt Request Router

The router takes a vector of maskable interrupt request lines and sends each one to one of two service targets: the main CPU or a coprocessor. Every source has its own configuration entry. The entry holds an enable bit, a programmable priority level and a bit that chooses the target. For each target, the router combinationally picks the enabled, pending request with the highest level that routes to it. The result is registered, and one cycle later the router presents a request strobe and a vector address.

The vector address joins a relocatable base register, which forms the upper byte, with a fixed per-source offset of two bytes per entry. Software reaches the entries through a small write/read bus. An index register selects the entry, a data register reaches that entry, and a third register holds the vector base. The CPU side is gated by a current-priority input: a CPU request appears only if the winning level is strictly above that input.

Top module: `irq_router`

## Requirements
- R1: While reset is low, both request strobes and both vectors read zero. After reset, every configuration entry, the index register and the vector base read zero.
- R2: Bus registers are chosen by bus_addr: 0 is the index, 1 is the configuration of the indexed source, and 2 is the vector base. In a configuration byte, bit 0 is the enable, bit 1 is the target (0 CPU, 1 coprocessor) and bits 4:2 are the priority. A write takes effect at the clock edge, and bus_rdata returns the written values combinationally.
- R3: A pending source that is disabled, or whose priority is 0, never produces a request on either target.
- R4: Among eligible pending sources routed to the same target, the one with the highest priority level is forwarded.
- R5: When eligible sources on one target share the highest level, the lowest source index wins.
- R6: A source appears only on the target its target bit selects.
- R7: cpu_req is raised only when the winning CPU level is strictly greater than cpu_ipl. The coprocessor target ignores cpu_ipl.
- R8: A forwarded vector equals {base, 8'h00} + 2 × source index.
- R9: The strobe and vector reflect the pending lines and configuration of the previous clock edge. With no request, the vector outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | 8 | Pending request lines, one per source |
| cpu_ipl | input | 3 | CPU current interrupt priority |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| cpu_req | output | 1 | Request strobe to the CPU |
| cpu_vec | output | 16 | Vector address for the CPU |
| cop_req | output | 1 | Request strobe to the coprocessor |
| cop_vec | output | 16 | Vector address for the coprocessor |

## Verification
The bench sets priority 0 with the enable set, and also a high priority with the enable clear. A router that treated either as eligible would forward a source that must stay silent. Equal-level ties are checked on both targets. A design that scanned from the wrong end, or used a non-strict compare, would return the higher index. The CPU gate is probed with the winning level equal to cpu_ipl and one above it, while a coprocessor request is pending under a high cpu_ipl. An off-by-one compare, or a gate applied to the wrong target, shows up as a missing or extra strobe. The vector base is changed between requests, which exposes a stale base or a wrong offset scale.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   typedef enum logic [1:0] {
      REG_INDEX  = 2'd0,
      REG_CONFIG = 2'd1,
      REG_BASE   = 2'd2
   } reg_sel_e;

   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_TGT_BIT  = 1;
   localparam int CFG_PRIO_LSB = 2;

   localparam bit TGT_CPU = 1'b0;
   localparam bit TGT_COP = 1'b1;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs import irq_router_pkg::*; #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter int DATA_W  = 8,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bus_wr,
   input  logic [1:0]                       bus_addr,
   input  logic [DATA_W-1:0]                bus_wdata,
   output logic [DATA_W-1:0]                bus_rdata,
   output logic [NUM_SRC-1:0]               en_o,
   output logic [NUM_SRC-1:0]               tgt_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_o,
   output logic [DATA_W-1:0]                base_o
);
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] cfg_rd;
   logic              wr_idx, wr_cfg, wr_base;

   assign wr_idx  = bus_wr && (bus_addr == REG_INDEX);
   assign wr_cfg  = bus_wr && (bus_addr == REG_CONFIG);
   assign wr_base = bus_wr && (bus_addr == REG_BASE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         base_q <= '0;
      end else begin
         if (wr_idx)  idx_q  <= bus_wdata[IDX_W-1:0];
         if (wr_base) base_q <= bus_wdata;
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_o[g]   <= 1'b0;
            tgt_o[g]  <= TGT_CPU;
            prio_o[g] <= '0;
         end else if (wr_cfg && (idx_q == IDX_W'(g))) begin
            en_o[g]   <= bus_wdata[CFG_EN_BIT];
            tgt_o[g]  <= bus_wdata[CFG_TGT_BIT];
            prio_o[g] <= bus_wdata[CFG_PRIO_LSB +: PRIO_W];
         end
      end
   end

   always_comb begin
      cfg_rd = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (idx_q == IDX_W'(i)) begin
            cfg_rd[CFG_EN_BIT]                = en_o[i];
            cfg_rd[CFG_TGT_BIT]               = tgt_o[i];
            cfg_rd[CFG_PRIO_LSB +: PRIO_W]    = prio_o[i];
         end
      end
   end

   always_comb begin
      case (bus_addr)
         REG_INDEX:  bus_rdata = DATA_W'(idx_q);
         REG_CONFIG: bus_rdata = cfg_rd;
         REG_BASE:   bus_rdata = base_q;
         default:    bus_rdata = '0;
      endcase
   end

   assign base_o = base_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 3,
   parameter bit TARGET  = 1'b0,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0]             pend_i,
   input  logic [NUM_SRC-1:0]             en_i,
   input  logic [NUM_SRC-1:0]             tgt_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                           valid_o,
   output logic [IDX_W-1:0]               idx_o,
   output logic [PRIO_W-1:0]              lvl_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      lvl_o   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend_i[i] && en_i[i] && (tgt_i[i] == TARGET) && (prio_i[i] > lvl_o)) begin
            valid_o = 1'b1;
            idx_o   = IDX_W'(i);
            lvl_o   = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/irq_router.sv
module irq_router import irq_router_pkg::*; #(
   parameter int NUM_SRC     = 8,
   parameter int PRIO_W      = 3,
   parameter int DATA_W      = 8,
   parameter int OFF_W       = 8,
   parameter int ENTRY_BYTES = 2,
   localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int VEC_W      = DATA_W + OFF_W,
   localparam int NUM_TGT    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_pend,
   input  logic [PRIO_W-1:0]  cpu_ipl,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               cpu_req,
   output logic [VEC_W-1:0]   cpu_vec,
   output logic               cop_req,
   output logic [VEC_W-1:0]   cop_vec
);
   if (DATA_W < CFG_PRIO_LSB + PRIO_W) begin : g_bad_cfg
      $error("irq_router: DATA_W too narrow for configuration fields");
   end
   if (DATA_W < IDX_W) begin : g_bad_idx
      $error("irq_router: DATA_W too narrow for source index");
   end
   if (NUM_SRC * ENTRY_BYTES > (1 << OFF_W)) begin : g_bad_off
      $error("irq_router: vector table does not fit below the base");
   end

   logic [NUM_SRC-1:0]             en_w, tgt_w;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
   logic [DATA_W-1:0]              vec_base;
   logic                           win_valid [NUM_TGT];
   logic [IDX_W-1:0]               win_idx   [NUM_TGT];
   logic [PRIO_W-1:0]              win_lvl   [NUM_TGT];
   logic                           fire      [NUM_TGT];
   logic                           req_q     [NUM_TGT];
   logic [VEC_W-1:0]               vec_q     [NUM_TGT];

   irq_cfg_regs #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .DATA_W  (DATA_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .en_o      (en_w),
      .tgt_o     (tgt_w),
      .prio_o    (prio_w),
      .base_o    (vec_base)
   );

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      irq_arbiter #(
         .NUM_SRC (NUM_SRC),
         .PRIO_W  (PRIO_W),
         .TARGET  (t[0])
      ) arb_i (
         .pend_i  (irq_pend),
         .en_i    (en_w),
         .tgt_i   (tgt_w),
         .prio_i  (prio_w),
         .valid_o (win_valid[t]),
         .idx_o   (win_idx[t]),
         .lvl_o   (win_lvl[t])
      );

      if (t == int'(TGT_CPU)) begin : g_gate
         assign fire[t] = win_valid[t] && (win_lvl[t] > cpu_ipl);
      end else begin : g_open
         assign fire[t] = win_valid[t];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            req_q[t] <= 1'b0;
            vec_q[t] <= '0;
         end else begin
            req_q[t] <= fire[t];
            vec_q[t] <= fire[t]
                      ? ({vec_base, {OFF_W{1'b0}}} + VEC_W'(win_idx[t]) * VEC_W'(ENTRY_BYTES))
                      : '0;
         end
      end
   end

   assign cpu_req = req_q[0];
   assign cpu_vec = vec_q[0];
   assign cop_req = req_q[1];
   assign cop_vec = vec_q[1];
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int NUM_SRC     = 8,
   parameter int PRIO_W      = 3,
   parameter int DATA_W      = 8,
   parameter int OFF_W       = 8,
   parameter int ENTRY_BYTES = 2,
   localparam int VEC_W      = DATA_W + OFF_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_pend,
   input logic [PRIO_W-1:0]  cpu_ipl,
   input logic [PRIO_W-1:0]  cpu_lvl,
   input logic [DATA_W-1:0]  vec_base,
   input logic               cpu_req,
   input logic [VEC_W-1:0]   cpu_vec,
   input logic               cop_req,
   input logic [VEC_W-1:0]   cop_vec
);
   AST_CPU_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> ($past(cpu_lvl) > $past(cpu_ipl)));                                   // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend == '0) |=> (!cpu_req && !cop_req));                                     // R3
   AST_CPU_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> (cpu_vec[VEC_W-1:OFF_W] == $past(vec_base)));                         // R8
   AST_COP_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_req |-> (cop_vec[VEC_W-1:OFF_W] == $past(vec_base)));                         // R8
   AST_COP_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cop_req |-> (int'(cop_vec[OFF_W-1:0]) < NUM_SRC * ENTRY_BYTES));                  // R8
   AST_CPU_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> (int'(cpu_vec[OFF_W-1:0]) < NUM_SRC * ENTRY_BYTES));                  // R8
   AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cop_req) |-> ($past(irq_pend) != '0));                                      // R9
   AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req |-> (cpu_vec == '0)) and (!cop_req |-> (cop_vec == '0)));               // R9
endmodule

bind irq_router irq_router_chk #(
   .NUM_SRC     (NUM_SRC),
   .PRIO_W      (PRIO_W),
   .DATA_W      (DATA_W),
   .OFF_W       (OFF_W),
   .ENTRY_BYTES (ENTRY_BYTES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_pend (irq_pend),
   .cpu_ipl  (cpu_ipl),
   .cpu_lvl  (win_lvl[0]),
   .vec_base (vec_base),
   .cpu_req  (cpu_req),
   .cpu_vec  (cpu_vec),
   .cop_req  (cop_req),
   .cop_vec  (cop_vec)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_pend = '0;
   logic [2:0]  cpu_ipl = '0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        cpu_req, cop_req;
   logic [15:0] cpu_vec, cop_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic        cr;
      logic [15:0] cv;
      logic        pr;
      logic [15:0] pv;
      string       tag;
   } exp_t;
   exp_t sb[$];
   exp_t cur;

   bit       m_en   [N];
   bit       m_tgt  [N];
   int       m_prio [N];
   logic [7:0] m_base = '0;

   always #5 clk = ~clk;

   irq_router dut_i (
      .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .cpu_ipl(cpu_ipl),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cop_req(cop_req), .cop_vec(cop_vec)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(bus_rdata == exp, tag, 16'(bus_rdata), 16'(exp));
   endtask

   // R2 layout: bit0 enable, bit1 target, bits4:2 priority
   task automatic cfg(input int i, input bit en, input bit tgt, input int prio);
      wr(2'd0, 8'(i));
      wr(2'd1, {3'b000, 3'(prio), tgt, en});
      m_en[i] = en; m_tgt[i] = tgt; m_prio[i] = prio;
   endtask

   task automatic set_base(input logic [7:0] b);
      wr(2'd2, b);
      m_base = b;
   endtask

   // driver: apply stimulus, push the expectation for the next edge
   task automatic apply(input logic [N-1:0] p, input logic [2:0] ipl, input string tag);
      exp_t e;
      int best [2];
      int bidx [2];
      @(negedge clk);
      irq_pend = p; cpu_ipl = ipl;
      best = '{0, 0}; bidx = '{0, 0};
      for (int i = 0; i < N; i++) begin
         int t;
         t = m_tgt[i] ? 1 : 0;
         if (p[i] && m_en[i] && m_prio[i] > best[t]) begin
            best[t] = m_prio[i]; bidx[t] = i;
         end
      end
      e.cr  = (best[0] > 0) && (best[0] > int'(ipl));
      e.cv  = e.cr ? ({m_base, 8'h00} + 16'(bidx[0] * 2)) : 16'h0;
      e.pr  = best[1] > 0;
      e.pv  = e.pr ? ({m_base, 8'h00} + 16'(bidx[1] * 2)) : 16'h0;
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
   endtask

   // monitor: compare after the edge that registers the result
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         check(cpu_req == cur.cr, {cur.tag, " cpu_req"}, 16'(cpu_req), 16'(cur.cr));
         check(cpu_vec == cur.cv, {cur.tag, " cpu_vec"}, cpu_vec, cur.cv);
         check(cop_req == cur.pr, {cur.tag, " cop_req"}, 16'(cop_req), 16'(cur.pr));
         check(cop_vec == cur.pv, {cur.tag, " cop_vec"}, cop_vec, cur.pv);
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_tgt[i] = 0; m_prio[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(cpu_req == 1'b0 && cop_req == 1'b0, "R1 strobes in reset", {14'b0, cpu_req, cop_req}, 16'h0);
      check(cpu_vec == 16'h0 && cop_vec == 16'h0, "R1 vectors in reset", cpu_vec | cop_vec, 16'h0);
      rst_n = 1'b1;
      rd(2'd2, 8'h00, "R1 base after reset");
      rd(2'd1, 8'h00, "R1 config after reset");
      rd(2'd0, 8'h00, "R1 index after reset");

      // R2 register access
      cfg(3, 1, 0, 5);
      rd(2'd0, 8'h03, "R2 index readback");
      rd(2'd1, 8'h15, "R2 config readback");
      set_base(8'h40);
      rd(2'd2, 8'h40, "R2 base readback");

      // R6 / R8 single CPU source
      apply(8'b0000_1000, 3'd0, "R6 R8 src3 to cpu");

      // R3 priority zero and disabled sources
      cfg(1, 1, 0, 0);
      cfg(2, 0, 0, 7);
      apply(8'b0000_0110, 3'd0, "R3 prio0 and disabled");

      // R4 highest level wins, both targets
      cfg(5, 1, 0, 6);
      apply(8'b0010_1000, 3'd0, "R4 cpu level 6 over 5");
      cfg(6, 1, 1, 2);
      cfg(7, 1, 1, 4);
      apply(8'b1100_1000, 3'd0, "R4 R6 cop level 4 over 2");

      // R5 ties go to lowest index
      cfg(0, 1, 0, 5);
      apply(8'b0000_1001, 3'd0, "R5 cpu tie src0");
      cfg(4, 1, 1, 4);
      apply(8'b1001_0000, 3'd0, "R5 cop tie src4");

      // R7 current-priority gate
      apply(8'b0000_1000, 3'd5, "R7 level equals ipl");
      apply(8'b0000_1000, 3'd4, "R7 level above ipl");
      apply(8'b1000_1000, 3'd7, "R7 cop ignores ipl");

      // R8 relocated base
      set_base(8'hA5);
      apply(8'b0010_0000, 3'd0, "R8 base A5 src5");
      apply(8'b1000_0000, 3'd0, "R8 base A5 src7 cop");

      // R9 idle drops strobes and vectors
      apply(8'b0000_0000, 3'd0, "R9 idle");
      apply(8'b0110_0000, 3'd2, "R9 back to back");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule